// File: doc/BRIEF.md
# DMA Channel Control and Status Register Unit

This unit holds the software-visible registers of a single DMA channel: a control/status word, a memory address, a byte count and an upper-address word. Software reaches them over a plain 32-bit register bus that accepts full-word writes only. Reads come back combinationally, and a write is a one-cycle strobe. The attached peripheral's data path, its address translation and the peripheral itself sit outside this unit.

Toward the peripheral the unit emits a one-cycle reset pulse and a level "DMA enabled" signal. From the peripheral it takes a level interrupt request, which becomes a pending flag in the control/status word. The unit drives a registered interrupt line toward the processor. The control/status word carries a fixed version code in its top bits. It also has bits that only hardware may change, and write side effects: a drain request is folded into the write, and writing the address register marks the channel as loaded.

Only address bits [3:2] select a register. The block therefore decodes correctly at a base address that is not aligned to a page.

Top module: `dma_chan_regs`

## Requirements
- R1: After synchronous reset, control/status reads 0xA0000000, the address, count and upper-address registers read 0, and all three outputs toward the processor and the peripheral are low.
- R2: The register index is bus_addr[3:2]: 0 is control/status, 1 is address, 2 is byte count and 3 is upper address. All other address bits are ignored on both reads and writes.
- R3: A write with bus_be other than 4'hF changes no register and produces no side effect.
- R4: Control/status bits 31:25 and 2:0 (mask 0xFE000007) ignore software writes. Bits 31:29 always read 3'b101 and bits 28:27 and 25 always read 0.
- R5: In control/status, bit 7 is the peripheral reset request and bit 6 is the drain request. If a write has bit 7 clear and bit 6 set, bit 6 is stored as 0. If a write has the value 0, bit 6 is stored as 1. If a write has bit 7 set, bit 6 is stored as written.
- R6: A control/status write with bit 7 set gives per_rst_o high for exactly the one cycle after the write edge.
- R7: per_dma_en_o equals control/status bit 9 (DMA enable). It rises when a write sets the bit and falls when a write clears it.
- R8: A write to the address register stores the value and sets control/status bit 26 (loaded). Writes to the count and upper-address registers store their values and leave control/status unchanged.
- R9: When per_req rises, control/status bit 0 (pending) is set on that edge. irq_o rises on the same edge only if bit 4 (interrupt enable) is set.
- R10: When per_req falls while pending is set, pending is cleared. irq_o falls on the same edge only if the interrupt enable bit is set.
- R11: On a control/status write, irq_o becomes 1 if the written enable bit is 1 and pending is set. It becomes 0 if the written enable bit is 0 and pending or the old enable bit was set. Otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_be | input | 4 | Byte enables; only 4'hF writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| per_req | input | 1 | Level interrupt request from the peripheral |
| irq_o | output | 1 | Registered interrupt to the processor |
| per_rst_o | output | 1 | One-cycle reset pulse to the peripheral |
| per_dma_en_o | output | 1 | DMA enabled level to the peripheral |

## Verification
The assertions check the following invariants on every cycle:
- the fixed version and zero bits of the status word;
- that an asserted interrupt implies both pending and enable are set;
- that the DMA-enable output matches its control bit;
- that the reset pulse appears only after a reset-bit write;
- that partial-width writes leave state alone;
- that address writes set the loaded flag.

The directed scenarios show what needs a chosen sequence:
- the drain-bit folding, including the all-zero value;
- address aliasing;
- the interrupt raised late by enabling while pending;
- a request that falls while the enable bit is clear, which clears pending without touching the line.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_REGS  = 4;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int IDX_LSB   = 2;
  localparam int WIN_BITS  = IDX_LSB + IDX_W;

  localparam int B_PEND    = 0;
  localparam int B_IEN     = 4;
  localparam int B_DRAIN   = 6;
  localparam int B_PRST    = 7;
  localparam int B_TOMEM   = 8;
  localparam int B_DMAEN   = 9;
  localparam int B_LOADED  = 26;

  localparam logic [DATA_W-1:0] RO_MASK     = 32'hFE00_0007;
  localparam logic [DATA_W-1:0] VERSION_VAL = 32'hA000_0000;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL  = 2'd0,
    IDX_ADDR  = 2'd1,
    IDX_COUNT = 2'd2,
    IDX_UPPER = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/dma_chan_regs_decode.sv
module dma_chan_regs_decode
  import dma_chan_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic [3:0]          be,
  output logic [IDX_W-1:0]    idx,
  output logic [NUM_REGS-1:0] wr_sel
);
  logic full_word;
  logic unused_addr_bits;

  assign idx              = addr[WIN_BITS-1:IDX_LSB];
  assign unused_addr_bits = ^{addr[ADDR_W-1:WIN_BITS], addr[IDX_LSB-1:0]};
  assign full_word        = wr && (be == 4'hF);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign wr_sel[g] = full_word && (idx == IDX_W'(g));
  end
endmodule

// File: rtl/dma_chan_regs_edge.sv
module dma_chan_regs_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl && !lvl_q;
  assign fall = !lvl && lvl_q;
endmodule

// File: rtl/dma_chan_regs_data.sv
module dma_chan_regs_data
  import dma_chan_regs_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REGS-1:0] wr_sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   reg_q [1:NUM_REGS-1]
);
  logic unused_sel0;
  assign unused_sel0 = wr_sel[0];

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            reg_q[g] <= '0;
      else if (wr_sel[g]) reg_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/dma_chan_regs_ctrl.sv
module dma_chan_regs_ctrl
  import dma_chan_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              req_rise,
  input  logic              req_fall,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              irq_q,
  output logic              prst_q,
  output logic              dmaen_q
);
  logic [DATA_W-1:0] wval;
  logic [DATA_W-1:0] ctrl_n;
  logic              irq_n;

  // Drain folding applied to the written value
  always_comb begin
    wval = wdata;
    if (!wdata[B_PRST]) begin
      if (wdata[B_DRAIN])   wval[B_DRAIN] = 1'b0;
      else if (wdata == '0) wval[B_DRAIN] = 1'b1;
    end
  end

  always_comb begin
    ctrl_n = ctrl_q;
    irq_n  = irq_q;
    // Peripheral request events
    if (req_rise) begin
      ctrl_n[B_PEND] = 1'b1;
      if (ctrl_q[B_IEN]) irq_n = 1'b1;
    end else if (req_fall && ctrl_q[B_PEND]) begin
      ctrl_n[B_PEND] = 1'b0;
      if (ctrl_q[B_IEN]) irq_n = 1'b0;
    end
    // Software write to control/status
    if (wr_ctrl) begin
      if (wval[B_IEN] && ctrl_n[B_PEND])
        irq_n = 1'b1;
      else if (!wval[B_IEN] && (ctrl_n[B_PEND] || ctrl_q[B_IEN]))
        irq_n = 1'b0;
      ctrl_n = (ctrl_n & RO_MASK) | (wval & ~RO_MASK);
    end
    if (wr_addr) ctrl_n[B_LOADED] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= VERSION_VAL;
      irq_q   <= 1'b0;
      prst_q  <= 1'b0;
      dmaen_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      irq_q  <= irq_n;
      prst_q <= wr_ctrl && wdata[B_PRST];
      if (wr_ctrl) begin
        if (wval[B_DMAEN] && !ctrl_q[B_DMAEN])      dmaen_q <= 1'b1;
        else if (!wval[B_DMAEN] && ctrl_q[B_DMAEN]) dmaen_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              per_req,
  output logic              irq_o,
  output logic              per_rst_o,
  output logic              per_dma_en_o
);
  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] wr_sel;
  logic                req_rise;
  logic                req_fall;
  logic [DATA_W-1:0]   ctrl_q;
  logic [DATA_W-1:0]   data_q [1:NUM_REGS-1];
  logic [DATA_W-1:0]   addr_q;

  dma_chan_regs_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr(bus_addr), .wr(bus_wr), .be(bus_be), .idx(idx), .wr_sel(wr_sel)
  );

  dma_chan_regs_edge edge_i (
    .clk(clk), .rst(rst), .lvl(per_req), .rise(req_rise), .fall(req_fall)
  );

  dma_chan_regs_data data_i (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wdata(bus_wdata), .reg_q(data_q)
  );

  dma_chan_regs_ctrl ctrl_i (
    .clk(clk), .rst(rst),
    .wr_ctrl(wr_sel[IDX_CTRL]), .wr_addr(wr_sel[IDX_ADDR]),
    .wdata(bus_wdata), .req_rise(req_rise), .req_fall(req_fall),
    .ctrl_q(ctrl_q), .irq_q(irq_o), .prst_q(per_rst_o), .dmaen_q(per_dma_en_o)
  );

  assign addr_q = data_q[IDX_ADDR];

  always_comb begin
    if (idx == IDX_CTRL) bus_rdata = ctrl_q;
    else                 bus_rdata = data_q[idx];
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic              per_req,
  input logic              irq_o,
  input logic              per_rst_o,
  input logic              per_dma_en_o,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       addr_q
);
  logic ctrl_wr_full;
  logic addr_wr_full;
  assign ctrl_wr_full = bus_wr && bus_be == 4'hF && bus_addr[3:2] == 2'd0;
  assign addr_wr_full = bus_wr && bus_be == 4'hF && bus_addr[3:2] == 2'd1;

  // R4
  version_bits_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[31:29] == 3'b101 && ctrl_q[28:27] == 2'b00 && !ctrl_q[25]);

  // R11
  irq_needs_pend_en_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (ctrl_q[0] && ctrl_q[4]));

  // R6
  rst_pulse_on_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr_full && bus_wdata[7]) |=> per_rst_o);

  // R6
  rst_pulse_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_wr_full && bus_wdata[7]) |=> !per_rst_o);

  // R7
  dma_en_match_chk: assert property (@(posedge clk) disable iff (rst)
    per_dma_en_o == ctrl_q[9]);

  // R8
  loaded_set_chk: assert property (@(posedge clk) disable iff (rst)
    addr_wr_full |=> (ctrl_q[26] && addr_q == $past(bus_wdata)));

  // R3
  partial_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_be != 4'hF) |=> ($stable(addr_q) && $stable(ctrl_q[31:1])));

  // R9
  rise_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(per_req) && !bus_wr && ctrl_q[4]) |=> irq_o);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
  .bus_wdata(bus_wdata), .per_req(per_req), .irq_o(irq_o), .per_rst_o(per_rst_o),
  .per_dma_en_o(per_dma_en_o), .ctrl_q(ctrl_q), .addr_q(addr_q)
);

// File: tb/dma_chan_regs_tb_top.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [3:0]        bus_be = 4'hF;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              per_req = 1'b0;
  logic              irq_o;
  logic              per_rst_o;
  logic              per_dma_en_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  dma_chan_regs #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_req(per_req),
    .irq_o(irq_o), .per_rst_o(per_rst_o), .per_dma_en_o(per_dma_en_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; per_req = 1'b0; bus_wr = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                           input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_req(input logic v);
    @(negedge clk);
    per_req = v;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    do_reset();
    bus_read(12'h000, d); check("R1 ctrl reset", d, 32'hA000_0000);
    bus_read(12'h004, d); check("R1 addr reset", d, 32'h0);
    bus_read(12'h008, d); check("R1 count reset", d, 32'h0);
    bus_read(12'h00C, d); check("R1 upper reset", d, 32'h0);
    check("R1 outputs low", {29'd0, irq_o, per_rst_o, per_dma_en_o}, 32'h0);
  endtask

  task automatic t_ctrl_write_side_effects();
    logic [31:0] d;
    do_reset();
    bus_write(12'h000, 32'hFFFF_FFFF);
    check("R6 reset pulse high", {31'd0, per_rst_o}, 32'h1);
    check("R7 dma enable rises", {31'd0, per_dma_en_o}, 32'h1);
    check("R11 irq stays low without pending", {31'd0, irq_o}, 32'h0);
    bus_read(12'h000, d); check("R4 R5 ctrl after all ones", d, 32'hA1FF_FFF8);
    @(negedge clk);
    check("R6 reset pulse one cycle", {31'd0, per_rst_o}, 32'h0);
    bus_write(12'h000, 32'h0);
    bus_read(12'h000, d); check("R5 zero write stores drain", d, 32'hA000_0040);
    check("R7 dma enable falls", {31'd0, per_dma_en_o}, 32'h0);
    check("R6 no pulse on zero write", {31'd0, per_rst_o}, 32'h0);
    bus_write(12'h000, 32'h0000_0240);
    bus_read(12'h000, d); check("R5 drain dropped", d, 32'hA000_0200);
    bus_write(12'h000, 32'h0000_0007);
    bus_read(12'h000, d); check("R4 low read-only bits", d, 32'hA000_0000);
  endtask

  task automatic t_data_regs();
    logic [31:0] d;
    do_reset();
    bus_write(12'h000, 32'h0000_0200);
    bus_write(12'h004, 32'h1234_5678);
    bus_read(12'h004, d); check("R8 addr stored", d, 32'h1234_5678);
    bus_read(12'h000, d); check("R8 loaded set", d, 32'hA400_0200);
    bus_write(12'h008, 32'h0000_CAFE);
    bus_write(12'h00C, 32'hFF00_0000);
    bus_read(12'h008, d); check("R8 count stored", d, 32'h0000_CAFE);
    bus_read(12'h00C, d); check("R8 upper stored", d, 32'hFF00_0000);
    bus_read(12'h000, d); check("R8 ctrl unchanged", d, 32'hA400_0200);
  endtask

  task automatic t_alias_and_partial();
    logic [31:0] d;
    do_reset();
    bus_write(12'h734, 32'hDEAD_BEEF);
    bus_read(12'h004, d); check("R2 alias write idx1", d, 32'hDEAD_BEEF);
    bus_write(12'h008, 32'h0000_1111);
    bus_read(12'hFFA, d); check("R2 alias read idx2", d, 32'h0000_1111);
    bus_write(12'h008, 32'h0000_0001, 4'h3);
    bus_read(12'h008, d); check("R3 partial count ignored", d, 32'h0000_1111);
    bus_write(12'h000, 32'h0000_0290, 4'h7);
    bus_read(12'h000, d); check("R3 partial ctrl ignored", d, 32'hA400_0000);
    check("R3 no pulse no enable", {30'd0, per_rst_o, per_dma_en_o}, 32'h0);
  endtask

  task automatic t_irq_enabled();
    logic [31:0] d;
    do_reset();
    bus_write(12'h000, 32'h0000_0010);
    set_req(1'b1);
    bus_read(12'h000, d); check("R9 pending set", d, 32'hA000_0011);
    check("R9 irq raised", {31'd0, irq_o}, 32'h1);
    set_req(1'b0);
    bus_read(12'h000, d); check("R10 pending cleared", d, 32'hA000_0010);
    check("R10 irq lowered", {31'd0, irq_o}, 32'h0);
  endtask

  task automatic t_irq_late_enable();
    logic [31:0] d;
    do_reset();
    bus_write(12'h000, 32'h0000_0100);
    set_req(1'b1);
    bus_read(12'h000, d); check("R9 pending without enable", d, 32'hA000_0101);
    check("R9 irq held low", {31'd0, irq_o}, 32'h0);
    bus_write(12'h000, 32'h0000_0110);
    check("R11 enable with pending raises irq", {31'd0, irq_o}, 32'h1);
    bus_write(12'h000, 32'h0000_0100);
    check("R11 enable clear lowers irq", {31'd0, irq_o}, 32'h0);
    set_req(1'b0);
    bus_read(12'h000, d); check("R10 pending cleared while disabled", d, 32'hA000_0100);
    check("R10 irq stays low", {31'd0, irq_o}, 32'h0);
  endtask

  initial begin
    t_reset_state();
    t_ctrl_write_side_effects();
    t_data_regs();
    t_alias_and_partial();
    t_irq_enabled();
    t_irq_late_enable();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule